// File: doc/BRIEF.md
# FSK Host Output Port

This block stands between a demodulated FSK bit stream and a host microcontroller. The incoming line carries asynchronous frames: a space start bit, eight data bits with the least significant bit first, and a mark stop bit. The bit stream is synchronous to `clk`, and one bit lasts `BIT_CLKS` clock cycles. A level on `mode_sel` chooses how the host gets the data. With streaming selected, the block passes the recovered bits straight through, drives its own data clock at each bit centre, and marks each byte boundary with a low ready strobe. With host-clocked selected, the block collects each byte internally, pulls ready low, and the host steps through the bits with rising edges on a clock that the host supplies.

A single held, low-active interrupt combines three event sources: the ring indication from a separate ring detector, the block's own ready signal, and the alert-tone detect flag from a separate tone detector. A synchronous high level on `rst` clears the port. This input also serves as the sleep control.

Top module: `fsk_host_port`

## Requirements
- R1: When `mode_sel` is 0, `dclk_oe` is 1 and the block drives `dclk_out`. When `mode_sel` is 1, `dclk_oe` is 0 and `dclk_out` stays 0.
- R2: In streaming mode, a frame is a 0 start bit, then `DATA_W` data bits sent LSB first, then a stop bit. While `demod_en` is high, `data_out` equals the `rx_bit` value seen at the previous clock edge (1 is mark, 0 is space).
- R3: In streaming mode, `dclk_out` makes one high pulse per data bit. The pulse rises one cycle after the edge that samples the bit centre and lasts `BIT_CLKS/2` cycles. `data_out` shows that data bit at the pulse's rising edge.
- R4: In streaming mode, `rdy_n` goes low for exactly `BIT_CLKS` cycles, centred on the stop-bit sample. Counting the start bit's first edge as cycle 0, the strobe runs from cycle 9·`BIT_CLKS` to cycle 10·`BIT_CLKS` − 1.
- R5: In host-clocked mode, a frame whose stop bit samples as mark loads a byte. On the next cycle `rdy_n` is 0 and `data_out` holds data bit 0.
- R6: In host-clocked mode, each rising edge of `dclk_in` is synchronised through `SYNC_STAGES` flops and moves `data_out` to the next bit, LSB first. After the eighth edge, `rdy_n` returns to 1 and `data_out` returns to 1.
- R7: If a new byte completes in host-clocked mode before all its bits are read, the new byte replaces the old one. `overrun` then goes to 1 and stays at 1 until reset.
- R8: In host-clocked mode, a frame whose stop bit samples as space delivers no byte, and `rdy_n` stays 1.
- R9: While `demod_en` is 0, no frame is received. `data_out` is 1 in streaming mode, `dclk_out` makes no pulses, and `rdy_n` makes no new strobe in either mode.
- R10: `irq_n` is 0 one cycle after any of these holds: `ring_n` is 0, `rdy_n` is 0, or `alert_hi` is 1. It is 1 one cycle after none of them holds.
- R11: While `rst` is high, at each clock edge `rdy_n`, `data_out` and `irq_n` go to 1, and `dclk_out` and `overrun` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset and sleep |
| mode_sel | input | 1 | 0 selects streaming, 1 selects host-clocked |
| demod_en | input | 1 | Enables reception of frames |
| rx_bit | input | 1 | Demodulated line bit, 1 is mark |
| dclk_in | input | 1 | Host shift clock (host-clocked mode) |
| ring_n | input | 1 | Ring indication, low active |
| alert_hi | input | 1 | Alert-tone detect, high active |
| dclk_out | output | 1 | Data clock driven by the block (streaming mode) |
| dclk_oe | output | 1 | High while the block drives the data clock |
| data_out | output | 1 | Serial data to the host |
| rdy_n | output | 1 | Byte boundary / byte-ready, low active |
| irq_n | output | 1 | Combined interrupt, low active |
| overrun | output | 1 | Sticky lost-byte flag |

## Verification
The bench builds the block with `BIT_CLKS` = 8, `DATA_W` = 8 and `SYNC_STAGES` = 2. A whole frame then takes about a hundred cycles, so a single run covers several streaming bytes, a double-byte overrun, a frame with a bad stop bit, frames sent with the enable low, and a reset while a byte is waiting. With a half-bit of four cycles, the data-clock pulse and the centred ready window each cover several cycles. This lets the per-clock model check their edges exactly. With two synchroniser stages, each host edge takes effect in a short, known delay.

// File: rtl/fsk_if_pkg.sv
package fsk_if_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/fsk_frame_rx.sv
// Frame receiver: finds the start bit, samples every bit at its centre,
// and collects the data bits LSB first.
module fsk_frame_rx
  import fsk_if_pkg::*;
#(
  parameter int BIT_CLKS = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rx_bit,
  output logic              bit_smp,
  output logic              stop_near,
  output logic              byte_ok,
  output logic [DATA_W-1:0] byte_val
);
  localparam int HALF = BIT_CLKS / 2;
  localparam int CW   = $clog2(BIT_CLKS);
  localparam int IW   = $clog2(DATA_W);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic              bit_end;

  assign bit_end   = (cnt == CW'(BIT_CLKS - 1));
  assign bit_smp   = en && (st == RX_DATA) && bit_end;
  assign stop_near = en && (st == RX_STOP) && (cnt == CW'(BIT_CLKS - HALF - 1));
  assign byte_ok   = en && (st == RX_STOP) && bit_end && rx_bit;
  assign byte_val  = sh;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st  <= RX_IDLE;
      cnt <= '0;
      idx <= '0;
    end else begin
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!rx_bit) st <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            idx <= '0;
            st  <= rx_bit ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (idx == IW'(DATA_W - 1)) begin
              idx <= '0;
              st  <= RX_STOP;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (bit_end) begin
            cnt <= '0;
            st  <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          sh <= '0;
    else if (bit_smp) sh <= {rx_bit, sh[DATA_W-1:1]};
  end
endmodule

// File: rtl/fsk_stream_out.sv
// Streaming output: bits pass straight through, a data clock pulses at
// each bit centre, and the ready strobe is centred on the stop bit.
module fsk_stream_out #(
  parameter int BIT_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic en,
  input  logic rx_bit,
  input  logic bit_smp,
  input  logic stop_near,
  output logic dclk,
  output logic data,
  output logic rdy_n
);
  localparam int HALF = BIT_CLKS / 2;
  localparam int CW   = $clog2(BIT_CLKS);

  logic [CW-1:0] dtmr;
  logic [CW-1:0] rtmr;

  always_ff @(posedge clk) begin
    if (rst) data <= 1'b1;
    else     data <= en ? rx_bit : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || !active) begin
      dclk <= 1'b0;
      dtmr <= '0;
    end else if (bit_smp) begin
      dclk <= 1'b1;
      dtmr <= CW'(HALF - 1);
    end else if (dclk) begin
      if (dtmr == '0) dclk <= 1'b0;
      else            dtmr <= dtmr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en || !active) begin
      rdy_n <= 1'b1;
      rtmr  <= '0;
    end else if (stop_near) begin
      rdy_n <= 1'b0;
      rtmr  <= CW'(BIT_CLKS - 1);
    end else if (!rdy_n) begin
      if (rtmr == '0) rdy_n <= 1'b1;
      else            rtmr  <= rtmr - 1'b1;
    end
  end
endmodule

// File: rtl/fsk_byte_buf.sv
// Host-clocked output: keeps the latest byte and shifts it out on
// synchronised rising edges of the host clock.
module fsk_byte_buf #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              host_clk,
  input  logic              byte_ok,
  input  logic [DATA_W-1:0] byte_val,
  output logic              data,
  output logic              rdy_n,
  output logic              overrun
);
  localparam int LW = $clog2(DATA_W + 1);

  logic [SYNC_STAGES:0] hs;
  logic                 rise;
  logic [DATA_W-1:0]    sh;
  logic [LW-1:0]        left;

  always_ff @(posedge clk) begin
    if (rst) hs <= '0;
    else     hs <= {hs[SYNC_STAGES-1:0], host_clk};
  end
  assign rise = hs[SYNC_STAGES-1] & ~hs[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      left    <= '0;
      rdy_n   <= 1'b1;
      data    <= 1'b1;
      overrun <= 1'b0;
    end else if (!active) begin
      left  <= '0;
      rdy_n <= 1'b1;
      data  <= 1'b1;
    end else if (byte_ok) begin
      sh    <= byte_val;
      left  <= LW'(DATA_W);
      rdy_n <= 1'b0;
      data  <= byte_val[0];
      if (left != '0) overrun <= 1'b1;
    end else if (rise && (left != '0)) begin
      sh   <= sh >> 1;
      left <= left - 1'b1;
      if (left == LW'(1)) begin
        rdy_n <= 1'b1;
        data  <= 1'b1;
      end else begin
        data <= sh[1];
      end
    end
  end
endmodule

// File: rtl/fsk_host_port.sv
module fsk_host_port #(
  parameter int BIT_CLKS    = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  input  logic demod_en,
  input  logic rx_bit,
  input  logic dclk_in,
  input  logic ring_n,
  input  logic alert_hi,
  output logic dclk_out,
  output logic dclk_oe,
  output logic data_out,
  output logic rdy_n,
  output logic irq_n,
  output logic overrun
);
  logic              bit_smp, stop_near, byte_ok;
  logic [DATA_W-1:0] byte_val;
  logic              s_dclk, s_data, s_rdy_n;
  logic              b_data, b_rdy_n;

  fsk_frame_rx #(.BIT_CLKS(BIT_CLKS), .DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst(rst), .en(demod_en), .rx_bit(rx_bit),
    .bit_smp(bit_smp), .stop_near(stop_near),
    .byte_ok(byte_ok), .byte_val(byte_val)
  );

  fsk_stream_out #(.BIT_CLKS(BIT_CLKS)) stream_i (
    .clk(clk), .rst(rst), .active(!mode_sel), .en(demod_en),
    .rx_bit(rx_bit), .bit_smp(bit_smp), .stop_near(stop_near),
    .dclk(s_dclk), .data(s_data), .rdy_n(s_rdy_n)
  );

  fsk_byte_buf #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) buf_i (
    .clk(clk), .rst(rst), .active(mode_sel), .host_clk(dclk_in),
    .byte_ok(byte_ok), .byte_val(byte_val),
    .data(b_data), .rdy_n(b_rdy_n), .overrun(overrun)
  );

  assign dclk_oe  = !mode_sel;
  assign dclk_out = mode_sel ? 1'b0 : s_dclk;
  assign data_out = mode_sel ? b_data : s_data;
  assign rdy_n    = mode_sel ? b_rdy_n : s_rdy_n;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ring_n & rdy_n & ~alert_hi;
  end
endmodule

// File: rtl/fsk_host_port_chk.sv
module fsk_host_port_chk #(
  parameter int BIT_CLKS = 16
) (
  input logic clk,
  input logic rst,
  input logic mode_sel,
  input logic demod_en,
  input logic ring_n,
  input logic alert_hi,
  input logic dclk_out,
  input logic data_out,
  input logic rdy_n,
  input logic irq_n,
  input logic overrun
);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_ring_irq_R10: assert property (@(posedge clk) disable iff (rst)
    !ring_n |=> !irq_n);

  assert_alert_irq_R10: assert property (@(posedge clk) disable iff (rst)
    alert_hi |=> !irq_n);

  assert_quiet_irq_R10: assert property (@(posedge clk) disable iff (rst)
    (ring_n && rdy_n && !alert_hi) |=> irq_n);

  assert_gated_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!demod_en && !mode_sel) |=> (mode_sel || (data_out && !dclk_out && rdy_n)));

  generate
    if (BIT_CLKS >= 4) begin : g_width
      assert_dclk_width_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(dclk_out) && demod_en && !mode_sel) |=> (dclk_out || !demod_en || mode_sel));

      assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(rdy_n) && demod_en && !mode_sel) |=> (!rdy_n || !demod_en || mode_sel));
    end
  endgenerate
endmodule

bind fsk_host_port fsk_host_port_chk #(.BIT_CLKS(BIT_CLKS)) chk_i (.*);

// File: tb/fsk_host_port_tb_top.sv
`timescale 1ns/1ps
module fsk_host_port_tb_top;
  localparam int BIT  = 8;
  localparam int HALF = BIT / 2;
  localparam int DW   = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst = 1'b1, mode_sel = 1'b0, demod_en = 1'b1;
  logic rx_bit = 1'b1, dclk_in = 1'b0, ring_n = 1'b1, alert_hi = 1'b0;
  logic dclk_out, dclk_oe, data_out, rdy_n, irq_n, overrun;

  int checks = 0, errors = 0, cyc = 0, fr_start = -1, ncap = 0;
  bit model_on = 1'b0;
  logic rx_q = 1'b1, en_q = 1'b1, irq_exp = 1'b1, dclk_prev = 1'b0;
  logic [DW-1:0] cap = '0;

  always #2.5 clk = ~clk;

  fsk_host_port #(.BIT_CLKS(BIT), .DATA_W(DW), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .demod_en(demod_en),
    .rx_bit(rx_bit), .dclk_in(dclk_in), .ring_n(ring_n), .alert_hi(alert_hi),
    .dclk_out(dclk_out), .dclk_oe(dclk_oe), .data_out(data_out),
    .rdy_n(rdy_n), .irq_n(irq_n), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Streaming model: cycle 0 is the first edge that sees the start bit.
  function automatic logic exp_rdy(input int c);
    int ls;
    if (fr_start < 0) return 1'b1;
    ls = fr_start + 1 + 9 * BIT;
    return !(c >= ls && c < ls + BIT);
  endfunction

  function automatic logic exp_dclk(input int c);
    logic v = 1'b0;
    if (fr_start < 0) return 1'b0;
    for (int i = 0; i < DW; i++) begin
      int s = fr_start + 1 + HALF + BIT * (i + 1);
      if (c >= s && c < s + HALF) v = 1'b1;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rx_q    <= rx_bit;
    en_q    <= demod_en;
    irq_exp <= rst ? 1'b1 : (ring_n & rdy_n & ~alert_hi);
  end

  always @(negedge clk) begin
    check(irq_n === irq_exp, "R10 irq_n", irq_n, irq_exp);
    if (!rst && mode_sel)
      check(dclk_oe === 1'b0 && dclk_out === 1'b0, "R1 host-clocked pin role",
            {dclk_oe, dclk_out}, 0);
    if (!rst && model_on) begin
      check(dclk_oe === 1'b1, "R1 streaming pin role", dclk_oe, 1);
      check(rdy_n === exp_rdy(cyc), "R4 strobe window", rdy_n, exp_rdy(cyc));
      check(dclk_out === exp_dclk(cyc), "R3 data clock", dclk_out, exp_dclk(cyc));
      check(data_out === (en_q ? rx_q : 1'b1), "R2/R9 data passthrough",
            data_out, en_q ? rx_q : 1'b1);
      if (dclk_out && !dclk_prev) begin
        if (ncap < DW) cap[ncap] = data_out;
        ncap++;
      end
      dclk_prev = dclk_out;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_bit = 1'b1; dclk_in = 1'b0; fr_start = -1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_frame(input logic [DW-1:0] b, input logic stop, input bit track);
    @(negedge clk);
    rx_bit = 1'b0;
    if (track) fr_start = cyc;
    for (int i = 0; i < DW; i++) begin
      repeat (BIT) @(negedge clk);
      rx_bit = b[i];
    end
    repeat (BIT) @(negedge clk);
    rx_bit = stop;
    repeat (BIT) @(negedge clk);
    rx_bit = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic host_pulse();
    @(negedge clk);
    dclk_in = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    dclk_in = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  task automatic read_byte(input logic [DW-1:0] b);
    for (int i = 0; i < DW; i++) begin
      host_pulse();
      if (i < DW - 1) begin
        check(data_out === b[i+1], "R6 next bit", data_out, b[i+1]);
        check(rdy_n === 1'b0, "R6 ready held", rdy_n, 0);
      end else begin
        check(rdy_n === 1'b1, "R6 ready released", rdy_n, 1);
        check(data_out === 1'b1, "R6 idle mark", data_out, 1);
      end
    end
  endtask

  task automatic stream_byte(input logic [DW-1:0] b);
    ncap = 0;
    send_frame(b, 1'b1, 1'b1);
    check(ncap == DW, "R3 pulse count", ncap, DW);
    check(cap === b, "R2 bits at clock edges", cap, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check(rdy_n === 1'b1, "R11 reset rdy_n", rdy_n, 1);
    check(data_out === 1'b1, "R11 reset data_out", data_out, 1);
    check(dclk_out === 1'b0, "R11 reset dclk_out", dclk_out, 0);
    check(overrun === 1'b0, "R11 reset overrun", overrun, 0);
    check(irq_n === 1'b1, "R11 reset irq_n", irq_n, 1);

    // streaming mode
    model_on = 1'b1;
    stream_byte(8'hA5);
    stream_byte(8'h3C);
    stream_byte(8'hFF);
    stream_byte(8'h01);
    demod_en = 1'b0;
    fr_start = -1;
    ncap = 0;
    send_frame(8'h5A, 1'b1, 1'b0);
    check(ncap == 0, "R9 no clock while disabled", ncap, 0);
    demod_en = 1'b1;
    stream_byte(8'h96);
    model_on = 1'b0;

    // host-clocked mode
    mode_sel = 1'b1;
    do_reset();
    send_frame(8'hA5, 1'b1, 1'b0);
    check(rdy_n === 1'b0, "R5 byte ready", rdy_n, 0);
    check(data_out === 1'b1, "R5 bit0 presented", data_out, 1);
    check(overrun === 1'b0, "R7 no overrun yet", overrun, 0);
    read_byte(8'hA5);

    send_frame(8'h3C, 1'b1, 1'b0);
    send_frame(8'hC2, 1'b1, 1'b0);
    check(overrun === 1'b1, "R7 overrun set", overrun, 1);
    check(rdy_n === 1'b0, "R7 newer byte ready", rdy_n, 0);
    check(data_out === 1'b0, "R7 newer byte bit0", data_out, 0);
    read_byte(8'hC2);
    check(overrun === 1'b1, "R7 overrun sticky", overrun, 1);

    send_frame(8'h77, 1'b0, 1'b0);
    check(rdy_n === 1'b1, "R8 bad stop dropped", rdy_n, 1);

    demod_en = 1'b0;
    send_frame(8'h11, 1'b1, 1'b0);
    check(rdy_n === 1'b1, "R9 no byte while disabled", rdy_n, 1);
    demod_en = 1'b1;

    // interrupt merge
    @(negedge clk); ring_n = 1'b0;
    repeat (2) @(negedge clk);
    check(irq_n === 1'b0, "R10 ring raises irq", irq_n, 0);
    ring_n = 1'b1; alert_hi = 1'b1;
    repeat (2) @(negedge clk);
    check(irq_n === 1'b0, "R10 alert raises irq", irq_n, 0);
    alert_hi = 1'b0;
    repeat (2) @(negedge clk);
    check(irq_n === 1'b1, "R10 irq released", irq_n, 1);
    send_frame(8'h81, 1'b1, 1'b0);
    check(irq_n === 1'b0, "R10 ready raises irq", irq_n, 0);

    // reset with a byte waiting and overrun set
    do_reset();
    check(rdy_n === 1'b1, "R11 reset clears ready", rdy_n, 1);
    check(overrun === 1'b0, "R11 reset clears overrun", overrun, 0);
    check(data_out === 1'b1, "R11 reset data mark", data_out, 1);
    @(negedge clk);
    check(irq_n === 1'b1, "R11 irq idle after reset", irq_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule